// File: doc/BRIEF.md
# DRAM Rank Boundary Address Decoder

This block turns a physical byte address into the DRAM channel and rank that hold it, for a memory controller with two channels of four ranks each. Software programs, through a small register write port, one 8-bit cumulative top-of-rank value per rank in units of 32 MiB, and one 8-bit attribute register per rank pair that carries a 3-bit page-size code for each rank of the pair. From these values the block works out whether the two channels are populated identically, which puts it in interleaved mode, and what the total installed memory is.

Each lookup request gives a registered result one cycle later: a miss flag, the channel and the rank. In interleaved mode each rank's span is twice the channel 0 boundary, and address bit 6 picks the channel, so consecutive 64-byte lines alternate between channels. Otherwise the channels are stacked: channel 0's ranks come first, and channel 1's ranks follow above channel 0's total.

Top module: `rank_decoder`

## Requirements
- R1: A write with `wr_en` high updates one register at the next clock edge. `wr_sel` 0..3 is the channel 0 boundary of ranks 0..3, 4..7 is the channel 1 boundary of ranks 0..3, 8 and 9 are the channel 0 attributes of ranks 0/1 and 2/3, and 10 and 11 are the same for channel 1. In an attribute byte, bits 2:0 hold the even rank's code and bits 6:4 the odd rank's code. Bits 7 and 3 are ignored, and so are writes with `wr_sel` 12..15.
- R2: A request with `addr_vld` high gives `res_vld` high exactly one cycle later, and `res_vld` is never high without such a request.
- R3: `total_size`, in units of 32 MiB, is twice channel 0's rank 3 boundary in interleaved mode. Otherwise it is the sum of both channels' rank 3 boundaries.
- R4: `interleaved` is high only when all four boundaries and all four rank codes are equal across the two channels.
- R5: In interleaved mode, rank r of channel 0 covers 32 MiB indices [2·B0[r-1], 2·B0[r]), where B0[-1] = 0. The result channel equals address bit 6.
- R6: In stacked mode, channel 0 rank r covers [B0[r-1], B0[r]), and channel 1 rank r covers [T0+B1[r-1], T0+B1[r]), where T0 is channel 0's rank 3 boundary. Address bit 6 has no effect.
- R7: A rank whose boundary equals the previous rank's boundary (or is zero, for rank 0) is never selected. The lookup moves on to the next rank that covers the index.
- R8: A rank is usable only with code 010, 011 or 100. Code 000 (unpopulated) or a reserved code (001, 101, 110, 111) makes an address in that rank's range a miss.
- R9: An address whose index (address bits 33:25) is at or above `total_size`, or that falls in no usable rank, gives `res_miss` high with `res_ch` and `res_rank` both zero.
- R10: After reset, all registers are zero, `interleaved` is high, `total_size` is zero and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select |
| wr_data | input | 8 | Register write data |
| addr_vld | input | 1 | Lookup request |
| addr | input | 34 | Physical byte address |
| res_vld | output | 1 | Lookup result valid |
| res_miss | output | 1 | Address not backed by a usable rank |
| res_ch | output | 1 | Selected channel |
| res_rank | output | 2 | Selected rank within the channel |
| interleaved | output | 1 | Both channels populated identically |
| total_size | output | 9 | Installed memory in 32 MiB units |

## Verification
A lookup's miss, channel and rank become visible one clock edge after its request, together with `res_vld`. The bench therefore queues each expectation when it drives the request and compares it only when `res_vld` shows up at a falling edge. `interleaved` and `total_size` follow the registers without delay, so they are checked at the falling edge right after the write's rising edge. Writes and lookups never share a cycle, so no result depends on the ordering between an update and a lookup.

// File: rtl/rank_decoder.sv
module rank_decoder #(
  parameter int ADDR_W   = 34,
  parameter int BND_W    = 8,
  parameter int GRAIN    = 25,
  parameter int LINE_BIT = 6,
  parameter int RANKS    = 4,
  parameter int SEL_W    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SEL_W-1:0]         wr_sel,
  input  logic [BND_W-1:0]         wr_data,
  input  logic                     addr_vld,
  input  logic [ADDR_W-1:0]        addr,
  output logic                     res_vld,
  output logic                     res_miss,
  output logic                     res_ch,
  output logic [$clog2(RANKS)-1:0] res_rank,
  output logic                     interleaved,
  output logic [ADDR_W-GRAIN-1:0]  total_size
);
  localparam int IDX_W  = ADDR_W - GRAIN;
  localparam int RANK_W = $clog2(RANKS);
  localparam int SLOTS  = 2 * RANKS;
  localparam int PAIRS  = RANKS / 2;

  logic [BND_W-1:0] bnd  [2][RANKS];
  logic [2:0]       attr [2][RANKS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++)
        for (int r = 0; r < RANKS; r++) begin
          bnd[c][r]  <= '0;
          attr[c][r] <= '0;
        end
    end else if (wr_en) begin
      for (int c = 0; c < 2; c++) begin
        for (int r = 0; r < RANKS; r++)
          if (wr_sel == SEL_W'(c * RANKS + r)) bnd[c][r] <= wr_data;
        for (int p = 0; p < PAIRS; p++)
          if (wr_sel == SEL_W'(2 * RANKS + c * PAIRS + p)) begin
            attr[c][2*p]   <= wr_data[2:0];
            attr[c][2*p+1] <= wr_data[6:4];
          end
      end
    end
  end

  logic [IDX_W-1:0] idx, total0, total1;
  logic [RANKS-1:0] eq_r;
  logic [IDX_W-1:0] hi [SLOTS];
  logic [IDX_W-1:0] lo [SLOTS];
  logic [SLOTS-1:0] slot_hit;

  assign idx         = addr[ADDR_W-1:GRAIN];
  assign total0      = IDX_W'(bnd[0][RANKS-1]);
  assign total1      = IDX_W'(bnd[1][RANKS-1]);
  assign interleaved = &eq_r;
  assign total_size  = interleaved ? (total0 << 1) : (total0 + total1);

  for (genvar r = 0; r < RANKS; r++) begin : g_eq
    assign eq_r[r] = (bnd[0][r] == bnd[1][r]) && (attr[0][r] == attr[1][r]);
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam int C = s / RANKS;
    localparam int R = s % RANKS;
    logic code_ok;
    assign code_ok = attr[C][R] inside {3'b010, 3'b011, 3'b100};
    if (C == 0) begin : g_c0
      assign hi[s] = interleaved ? {bnd[0][R], 1'b0} : IDX_W'(bnd[0][R]);
    end else begin : g_c1
      assign hi[s] = total0 + IDX_W'(bnd[1][R]);
    end
    if (R == 0) begin : g_first
      assign lo[s] = (C == 1) ? total0 : '0;
    end else begin : g_next
      assign lo[s] = hi[s-1];
    end
    assign slot_hit[s] = !(interleaved && C == 1) && code_ok &&
                         (lo[s] <= idx) && (idx < hi[s]);
  end

  logic              found, f_ch;
  logic [RANK_W-1:0] f_rank;

  always_comb begin
    found  = 1'b0;
    f_ch   = 1'b0;
    f_rank = '0;
    for (int s = 0; s < SLOTS; s++)
      if (!found && slot_hit[s]) begin
        found  = 1'b1;
        f_ch   = (s >= RANKS);
        f_rank = RANK_W'(s % RANKS);
      end
  end

  logic hit;
  assign hit = found && (idx < total_size);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld  <= 1'b0;
      res_miss <= 1'b0;
      res_ch   <= 1'b0;
      res_rank <= '0;
    end else begin
      res_vld <= addr_vld;
      if (addr_vld) begin
        res_miss <= !hit;
        res_ch   <= hit && (interleaved ? addr[LINE_BIT] : f_ch);
        res_rank <= hit ? f_rank : '0;
      end
    end
  end
endmodule

// File: rtl/rank_decoder_chk.sv
module rank_decoder_chk #(
  parameter int ADDR_W   = 34,
  parameter int GRAIN    = 25,
  parameter int LINE_BIT = 6,
  parameter int RANK_W   = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    addr_vld,
  input logic [ADDR_W-1:0]       addr,
  input logic                    res_vld,
  input logic                    res_miss,
  input logic                    res_ch,
  input logic [RANK_W-1:0]       res_rank,
  input logic                    interleaved,
  input logic [ADDR_W-GRAIN-1:0] total_size
);
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld |=> res_vld);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |=> !res_vld);
  a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld && res_miss |-> (res_ch == 1'b0) && (res_rank == '0));
  a_r9_above_total: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld && (addr[ADDR_W-1:GRAIN] >= total_size) |=> res_miss);
  a_r5_line_channel: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld && interleaved |=> res_miss || (res_ch == $past(addr[LINE_BIT])));
  a_r3_even_total: assert property (@(posedge clk) disable iff (!rst_n)
    interleaved |-> total_size[0] == 1'b0);
endmodule

bind rank_decoder rank_decoder_chk #(
  .ADDR_W(ADDR_W), .GRAIN(GRAIN), .LINE_BIT(LINE_BIT), .RANK_W($clog2(RANKS))
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .addr(addr),
  .res_vld(res_vld), .res_miss(res_miss), .res_ch(res_ch),
  .res_rank(res_rank), .interleaved(interleaved), .total_size(total_size)
);

// File: tb/tb_rank_decoder.sv
module tb_rank_decoder;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, addr_vld = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic [33:0] addr = '0;
  logic        res_vld, res_miss, res_ch, interleaved;
  logic [1:0]  res_rank;
  logic [8:0]  total_size;

  rank_decoder dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .addr_vld(addr_vld), .addr(addr), .res_vld(res_vld), .res_miss(res_miss),
    .res_ch(res_ch), .res_rank(res_rank), .interleaved(interleaved),
    .total_size(total_size)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct { bit miss; bit ch; int rank; string tag; } exp_t;
  exp_t q[$];
  exp_t e;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic check(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && res_vld) begin
      if (q.size() == 0) check(1'b0, "R2 spurious result", 1, 0);
      else begin
        e = q.pop_front();
        check(res_miss == e.miss, {e.tag, " miss"}, res_miss, e.miss);
        check(res_ch == e.ch, {e.tag, " channel"}, res_ch, e.ch);
        check(res_rank == e.rank[1:0], {e.tag, " rank"}, res_rank, e.rank);
      end
    end
  end

  task automatic wr(int sel, int data);
    @(negedge clk);
    addr_vld <= 1'b0;
    wr_en    <= 1'b1;
    wr_sel   <= sel[3:0];
    wr_data  <= data[7:0];
    @(negedge clk);
    wr_en <= 1'b0;
  endtask

  task automatic look(int idx, bit b6, bit m, bit c, int r, string tag);
    exp_t x;
    @(negedge clk);
    addr     <= (34'(idx) << 25) | (34'(b6) << 6);
    addr_vld <= 1'b1;
    x.miss = m; x.ch = c; x.rank = r; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic idle();
    @(negedge clk);
    addr_vld <= 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(interleaved == 1'b1, "R10 interleaved after reset", interleaved, 1);
    check(total_size == 0, "R10 total after reset", total_size, 0);
    check(res_vld == 1'b0, "R10 res_vld after reset", res_vld, 0);
    look(0, 0, 1, 0, 0, "R10 lookup after reset");
    idle();

    for (int c = 0; c < 2; c++) begin
      wr(c*4+0, 4); wr(c*4+1, 8); wr(c*4+2, 8); wr(c*4+3, 12);
    end
    wr(8, 8'h32); wr(9, 8'h40); wr(10, 8'h32); wr(11, 8'hC8);
    check(interleaved == 1'b1, "R1 reserved bits ignored / R4 match", interleaved, 1);
    check(total_size == 24, "R3 interleaved total", total_size, 24);
    look(0, 0, 0, 0, 0, "R5 idx0 line0");
    look(7, 1, 0, 1, 0, "R5 idx7 line1");
    look(8, 0, 0, 0, 1, "R5 idx8");
    look(15, 1, 0, 1, 1, "R5 idx15");
    look(16, 0, 0, 0, 3, "R7 empty rank2 skipped");
    look(23, 1, 0, 1, 3, "R7 idx23");
    look(24, 1, 1, 0, 0, "R9 at total");
    look(300, 0, 1, 0, 0, "R9 far above total");
    idle();

    wr(7, 14);
    check(interleaved == 1'b0, "R4 boundary mismatch", interleaved, 0);
    check(total_size == 26, "R3 stacked total", total_size, 26);
    look(3, 1, 0, 0, 0, "R6 bit6 no effect");
    look(11, 0, 0, 0, 3, "R6 ch0 top rank");
    look(12, 0, 0, 1, 0, "R6 ch1 above ch0 total");
    look(19, 1, 0, 1, 1, "R6 ch1 rank1");
    look(20, 0, 0, 1, 3, "R7 ch1 empty rank2 skipped");
    look(25, 0, 0, 1, 3, "R6 last index");
    look(26, 0, 1, 0, 0, "R9 stacked at total");
    idle();

    wr(7, 12);
    check(interleaved == 1'b1, "R4 match restored", interleaved, 1);
    wr(10, 8'h22);
    check(interleaved == 1'b0, "R4 code mismatch", interleaved, 0);
    check(total_size == 24, "R3 stacked total 12+12", total_size, 24);
    wr(8, 8'h52);
    look(5, 0, 1, 0, 0, "R8 reserved code misses");
    look(2, 0, 0, 0, 0, "R8 valid code hits");
    look(13, 1, 0, 1, 0, "R6 ch1 rank0");
    idle();
    wr(8, 8'h30);
    look(0, 0, 1, 0, 0, "R8 unpopulated code misses");
    look(4, 0, 0, 0, 1, "R8 code 011 hits");
    idle();
    wr(13, 8'hFF);
    check(total_size == 24, "R1 unused select ignored total", total_size, 24);
    check(interleaved == 1'b0, "R1 unused select ignored mode", interleaved, 0);
    look(4, 0, 0, 0, 1, "R1 unused select ignored lookup");
    idle();
    repeat (2) @(negedge clk);
    check(q.size() == 0, "R2 all results returned", q.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule